// File: doc/BRIEF.md
# WFI-Gated Module Reset Controller

This block holds one control word that lets privileged software request a power-on reset of any of the processor cores, or of the shared level-2 memory controller. A request is only carried out while the target module reports that it is idle in wait-for-interrupt (WFI). The hardware then holds that module's active-low reset for a fixed number of clock cycles and releases it by itself. Software never has to write the request back to 0: the request bit clears itself when the sequence ends.

A request written while the module is busy is kept as pending. It starts on the first cycle in which both the request bit and that module's WFI input are high. Only a cold reset clears the control word. A warm reset returns every sequencer to idle and releases all module resets, but pending requests survive it. The word accepts writes only from privileged bus accesses. An unprivileged read returns zero and raises an error flag for one cycle.

Each target module has its own sequencer with four states: `SEQ_IDLE` (no request), `SEQ_PEND` (request waiting for WFI), `SEQ_HOLD` (reset asserted, hold counter running) and `SEQ_DONE` (reset released, request bit being cleared). The transitions are:
- **IDLE->HOLD** when the request is set and WFI is high.
- **IDLE->PEND** when the request is set and WFI is low.
- **PEND->HOLD** when WFI rises.
- **PEND->IDLE** when the request has vanished.
- **HOLD->DONE** once the hold count reaches its limit.
- **DONE->IDLE** unconditionally.

Top module: `wfi_reset_ctrl`

## Requirements
- R1: After a cold reset the control word reads 0x0000_0000, every reset output is high and `bus_err` is low.
- R2: In the control word at offset 0x34, bit k (k = 0..3) requests a reset of core k and bit 8 requests a reset of the L2 controller. Writing a 1 affects only the module that bit names. All other bits are ignored on write and read as 0.
- R3: A module's reset output goes low in the clock cycle after the first cycle in which its request bit and its WFI input are both high. While its WFI input is low, the output stays high and the request bit reads 1.
- R4: Once low, a module's reset output stays low for exactly HOLD_CYC cycles (default 32) and then returns high with no bus access.
- R5: A request bit reads 0 from the second cycle after its module's reset has been released. A reset output is never low while its request bit is 0.
- R6: Writing 0 to a set request bit leaves it set.
- R7: A warm reset drives every reset output high and leaves the request bits unchanged. A pending request starts once WFI is high after the warm reset.
- R8: A cold reset clears every request bit, so a request made before it never produces a module reset.
- R9: A write with `bus_priv` low changes no request bit.
- R10: A read with `bus_priv` low returns 0 on `bus_rdata` and raises `bus_err` for exactly one cycle, in the cycle after the request.
- R11: A privileged read returns the control word in the cycle after the request with `bus_err` low. An access to any other address neither changes the word nor raises `bus_err`, and reads as 0.
- R12: Requests to several modules are sequenced independently and at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| cold_rst_n | input | 1 | Active-low cold reset; clears the control word and all state |
| warm_rst_n | input | 1 | Active-low warm reset; resets sequencers and bus response only |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_priv | input | 1 | 1 = privileged access |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| bus_err | output | 1 | One-cycle error response to an unprivileged read |
| core_wfi | input | N_CORES | Per-core WFI status |
| l2_wfi | input | 1 | L2 controller idle status |
| core_por_n | output | N_CORES | Active-low power-on reset to each core |
| l2_rst_n | output | 1 | Active-low reset to the L2 controller |

## Verification
Suppose a sequencer were stuck in the wrong state or its hold counter were off. A module's reset output would then fall without a preceding WFI cycle, or stay low for a number of cycles other than HOLD_CYC. Either fault shows on the output pin within HOLD_CYC plus one cycles of the request. A request bit that failed to set, clear or persist would appear on the next privileged read. It would also show as a reset that never happens, or a reset that repeats after the release. A corrupted bus response flop would show as nonzero data or a missing or stretched error pulse in the cycle right after an unprivileged read.

// File: rtl/wrc_pkg.sv
package wrc_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_PEND,
        SEQ_HOLD,
        SEQ_DONE
    } seq_state_e;

    // Bit position in the control word of target module idx:
    // cores occupy the low bits in order, the L2 controller sits at l2_bit.
    function automatic int unsigned field_bit(input int unsigned idx,
                                              input int unsigned n_cores,
                                              input int unsigned l2_bit);
        return (idx < n_cores) ? idx : l2_bit;
    endfunction

endpackage

// File: rtl/wrc_seq.sv
module wrc_seq #(
    parameter int unsigned HOLD_CYC = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic wfi,
    output logic mod_rst_n,
    output logic clr
);
    import wrc_pkg::*;

    localparam int unsigned CNT_W = $clog2(HOLD_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYC - 1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = '0;
        unique case (state_q)
            SEQ_IDLE: begin
                if (req && wfi)      state_d = SEQ_HOLD;
                else if (req)        state_d = SEQ_PEND;
            end
            SEQ_PEND: begin
                if (!req)            state_d = SEQ_IDLE;
                else if (wfi)        state_d = SEQ_HOLD;
            end
            SEQ_HOLD: begin
                if (cnt_q == CNT_LAST) state_d = SEQ_DONE;
                else                   cnt_d   = cnt_q + 1'b1;
            end
            SEQ_DONE: begin
                state_d = SEQ_IDLE;
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        mod_rst_n = 1'b1;
        clr       = 1'b0;
        unique case (state_q)
            SEQ_IDLE: ;
            SEQ_PEND: ;
            SEQ_HOLD: mod_rst_n = 1'b0;
            SEQ_DONE: clr       = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/wrc_regs.sv
module wrc_regs #(
    parameter int unsigned N_CORES    = 4,
    parameter int unsigned L2_BIT     = 8,
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned DATA_W     = 32,
    parameter logic [ADDR_W-1:0] REG_OFFSET = ADDR_W'('h34),
    localparam int unsigned NMOD      = N_CORES + 1
) (
    input  logic              clk,
    input  logic              cold_rst_n,
    input  logic              bus_rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_priv,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [NMOD-1:0]   clr,
    output logic [NMOD-1:0]   fields,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err
);
    import wrc_pkg::*;

    logic              addr_hit;
    logic              wr_ok;
    logic              rd_req;
    logic [NMOD-1:0]   set;
    logic [DATA_W-1:0] rd_img;
    logic              unused_wdata;

    assign addr_hit     = (bus_addr == REG_OFFSET);
    assign wr_ok        = bus_sel && bus_wr && bus_priv && addr_hit;
    assign rd_req       = bus_sel && !bus_wr && addr_hit;
    assign unused_wdata = ^bus_wdata;

    genvar gi;
    generate
        for (gi = 0; gi < NMOD; gi++) begin : g_field
            localparam int unsigned POS = field_bit(gi, N_CORES, L2_BIT);
            assign set[gi] = wr_ok && bus_wdata[POS];

            // Request bit: a new request wins over the self-clear.
            always_ff @(posedge clk or negedge cold_rst_n) begin
                if (!cold_rst_n)      fields[gi] <= 1'b0;
                else if (set[gi])     fields[gi] <= 1'b1;
                else if (clr[gi])     fields[gi] <= 1'b0;
            end
        end
    endgenerate

    always_comb begin
        rd_img = '0;
        for (int i = 0; i < NMOD; i++) begin
            rd_img[field_bit(i, N_CORES, L2_BIT)] = fields[i];
        end
    end

    always_ff @(posedge clk or negedge bus_rst_n) begin
        if (!bus_rst_n) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_rdata <= (rd_req && bus_priv) ? rd_img : '0;
            bus_err   <= rd_req && !bus_priv;
        end
    end

endmodule

// File: rtl/wfi_reset_ctrl.sv
module wfi_reset_ctrl #(
    parameter int unsigned N_CORES    = 4,
    parameter int unsigned L2_BIT     = 8,
    parameter int unsigned HOLD_CYC   = 32,
    parameter int unsigned ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] REG_OFFSET = ADDR_W'('h34)
) (
    input  logic               clk,
    input  logic               cold_rst_n,
    input  logic               warm_rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic               bus_priv,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               bus_err,
    input  logic [N_CORES-1:0] core_wfi,
    input  logic               l2_wfi,
    output logic [N_CORES-1:0] core_por_n,
    output logic               l2_rst_n
);
    localparam int unsigned NMOD = N_CORES + 1;

    logic            seq_rst_n;
    logic [NMOD-1:0] wfi_all;
    logic [NMOD-1:0] fields;
    logic [NMOD-1:0] clr;
    logic [NMOD-1:0] mod_rst_n;

    assign seq_rst_n = cold_rst_n & warm_rst_n;
    assign wfi_all   = {l2_wfi, core_wfi};

    wrc_regs #(
        .N_CORES   (N_CORES),
        .L2_BIT    (L2_BIT),
        .ADDR_W    (ADDR_W),
        .DATA_W    (32),
        .REG_OFFSET(REG_OFFSET)
    ) u_regs (
        .clk       (clk),
        .cold_rst_n(cold_rst_n),
        .bus_rst_n (seq_rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_priv  (bus_priv),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .clr       (clr),
        .fields    (fields),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err)
    );

    genvar gm;
    generate
        for (gm = 0; gm < NMOD; gm++) begin : g_seq
            wrc_seq #(
                .HOLD_CYC(HOLD_CYC)
            ) u_seq (
                .clk      (clk),
                .rst_n    (seq_rst_n),
                .req      (fields[gm]),
                .wfi      (wfi_all[gm]),
                .mod_rst_n(mod_rst_n[gm]),
                .clr      (clr[gm])
            );
        end
    endgenerate

    assign core_por_n = mod_rst_n[N_CORES-1:0];
    assign l2_rst_n   = mod_rst_n[N_CORES];

endmodule

// File: rtl/wrc_checker.sv
module wrc_checker #(
    parameter int unsigned N_CORES  = 4,
    parameter int unsigned HOLD_CYC = 32,
    localparam int unsigned NMOD    = N_CORES + 1,
    localparam int unsigned LC_W    = $clog2(HOLD_CYC + 2) + 1
) (
    input logic            clk,
    input logic            cold_rst_n,
    input logic            warm_rst_n,
    input logic            bus_sel,
    input logic            bus_wr,
    input logic            bus_priv,
    input logic [31:0]     bus_rdata,
    input logic            bus_err,
    input logic [NMOD-1:0] wfi_all,
    input logic [NMOD-1:0] fields,
    input logic [NMOD-1:0] mod_rst_n
);
    logic any_rst_n;
    assign any_rst_n = cold_rst_n & warm_rst_n;

    // R10: error response carries no data and follows an unprivileged read
    a_r10_err_zero_data: assert property (@(posedge clk) disable iff (!any_rst_n)
        bus_err |-> (bus_rdata == 32'h0));
    a_r10_err_cause: assert property (@(posedge clk) disable iff (!any_rst_n)
        bus_err |-> $past(bus_sel && !bus_wr && !bus_priv));

    genvar gc;
    generate
        for (gc = 0; gc < NMOD; gc++) begin : g_chk
            logic [LC_W-1:0] low_cnt;

            always_ff @(posedge clk or negedge any_rst_n) begin
                if (!any_rst_n)                      low_cnt <= '0;
                else if (mod_rst_n[gc])              low_cnt <= '0;
                else if (low_cnt != {LC_W{1'b1}})    low_cnt <= low_cnt + 1'b1;
            end

            // R3: reset only starts after a cycle with request and WFI both high
            a_r3_wfi_gate: assert property (@(posedge clk) disable iff (!any_rst_n)
                $fell(mod_rst_n[gc]) |-> $past(wfi_all[gc] && fields[gc]));

            // R4: reset is held exactly HOLD_CYC cycles
            a_r4_hold_len: assert property (@(posedge clk) disable iff (!any_rst_n)
                $rose(mod_rst_n[gc]) |-> (low_cnt == LC_W'(HOLD_CYC)));

            // R5: no reset without a standing request
            a_r5_rst_needs_req: assert property (@(posedge clk) disable iff (!any_rst_n)
                !mod_rst_n[gc] |-> fields[gc]);

            // R9: a request bit only rises after a privileged write
            a_r9_priv_set: assert property (@(posedge clk) disable iff (!any_rst_n)
                $rose(fields[gc]) |-> $past(bus_sel && bus_wr && bus_priv));
        end
    endgenerate

endmodule

bind wfi_reset_ctrl wrc_checker #(
    .N_CORES (N_CORES),
    .HOLD_CYC(HOLD_CYC)
) u_chk (
    .clk       (clk),
    .cold_rst_n(cold_rst_n),
    .warm_rst_n(warm_rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_priv  (bus_priv),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .wfi_all   (wfi_all),
    .fields    (fields),
    .mod_rst_n (mod_rst_n)
);

// File: tb/wfi_reset_ctrl_test.sv
module wfi_reset_ctrl_test;
    localparam int unsigned HOLD = 8;
    localparam int unsigned NC   = 4;
    localparam logic [11:0] REG_A = 12'h034;

    typedef struct packed {
        logic [31:0] wdata;
        logic [4:0]  wfi;   // {l2, core3..core0}
        logic [4:0]  low;   // expected low reset outputs, same order
        logic [31:0] rd;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{32'h0000_0001, 5'h1F, 5'h01, 32'h0000_0001},
        '{32'h0000_0100, 5'h1F, 5'h10, 32'h0000_0100},
        '{32'h0000_010F, 5'h15, 5'h15, 32'h0000_010F},
        '{32'hFFFF_FEF0, 5'h1F, 5'h00, 32'h0000_0000},
        '{32'h0000_000A, 5'h00, 5'h00, 32'h0000_000A},
        '{32'h0000_0008, 5'h08, 5'h08, 32'h0000_0008}
    };

    logic          clk = 1'b0;
    logic          cold_rst_n, warm_rst_n;
    logic          bus_sel, bus_wr, bus_priv;
    logic [11:0]   bus_addr;
    logic [31:0]   bus_wdata, bus_rdata;
    logic          bus_err;
    logic [NC-1:0] core_wfi, core_por_n;
    logic          l2_wfi, l2_rst_n;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    wfi_reset_ctrl #(.N_CORES(NC), .HOLD_CYC(HOLD)) uut (
        .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_priv(bus_priv),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .core_wfi(core_wfi), .l2_wfi(l2_wfi),
        .core_por_n(core_por_n), .l2_rst_n(l2_rst_n)
    );

    function automatic logic [4:0] lowmask();
        return ~{l2_rst_n, core_por_n};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic set_wfi(input logic [4:0] m);
        {l2_wfi, core_wfi} = m;
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d, input logic p);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_priv = p;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [11:0] a, input logic p,
                            output logic [31:0] d, output logic e);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_priv = p;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
        e = bus_err;
    endtask

    task automatic drain();
        set_wfi(5'h1F);
        repeat (HOLD + 6) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got 0x0 expected 0x1 (run did not finish)");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        logic        er;
        int          n;

        cold_rst_n = 1'b0; warm_rst_n = 1'b1;
        bus_sel = 1'b0; bus_wr = 1'b0; bus_priv = 1'b0;
        bus_addr = '0; bus_wdata = '0;
        set_wfi(5'h00);
        repeat (3) @(negedge clk);
        cold_rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 outputs high", {27'h0, lowmask()}, 32'h0);
        bus_read(REG_A, 1'b1, rd, er);
        check("R1 word zero", rd, 32'h0);
        check("R1 no error", {31'h0, er}, 32'h0);

        // R2 / R3 / R12: table of field patterns
        foreach (VECS[v]) begin
            set_wfi(VECS[v].wfi);
            bus_write(REG_A, VECS[v].wdata, 1'b1);
            @(negedge clk);
            check($sformatf("R2 R3 R12 vec%0d low mask", v), {27'h0, lowmask()}, {27'h0, VECS[v].low});
            bus_read(REG_A, 1'b1, rd, er);
            check($sformatf("R2 vec%0d readback", v), rd, VECS[v].rd);
            drain();
            check($sformatf("R4 vec%0d released", v), {27'h0, lowmask()}, 32'h0);
            bus_read(REG_A, 1'b1, rd, er);
            check($sformatf("R5 vec%0d cleared", v), rd, 32'h0);
        end

        // R4 / R5: exact hold length and self-clear
        set_wfi(5'h1F);
        bus_write(REG_A, 32'h4, 1'b1);
        n = 0;
        for (int k = 0; k < 4 * HOLD; k++) begin
            @(negedge clk);
            if (!core_por_n[2]) n++;
            else if (n > 0) break;
        end
        check("R4 hold cycles", n, HOLD);
        bus_read(REG_A, 1'b1, rd, er);
        check("R5 self-clear", rd, 32'h0);

        // R3 / R6: pending request, write 0, then WFI start timing
        set_wfi(5'h00);
        bus_write(REG_A, 32'h2, 1'b1);
        bus_write(REG_A, 32'h0, 1'b1);
        repeat (4) @(negedge clk);
        check("R3 pending stays high", {28'h0, core_por_n}, 32'hF);
        bus_read(REG_A, 1'b1, rd, er);
        check("R6 write zero no effect", rd, 32'h2);
        set_wfi(5'h02);
        @(negedge clk);
        check("R3 start after wfi", {27'h0, lowmask()}, 32'h02);
        drain();

        // R7: warm reset keeps pending requests
        set_wfi(5'h00);
        bus_write(REG_A, 32'h1, 1'b1);
        warm_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        warm_rst_n = 1'b1;
        bus_read(REG_A, 1'b1, rd, er);
        check("R7 word kept", rd, 32'h1);
        // R7: warm reset during a hold releases the output
        set_wfi(5'h01);
        @(negedge clk);
        check("R7 pending starts", {27'h0, lowmask()}, 32'h01);
        warm_rst_n = 1'b0;
        @(negedge clk);
        check("R7 warm releases", {27'h0, lowmask()}, 32'h00);
        warm_rst_n = 1'b1;
        drain();

        // R8: cold reset clears requests
        set_wfi(5'h00);
        bus_write(REG_A, 32'h100, 1'b1);
        cold_rst_n = 1'b0;
        @(negedge clk);
        cold_rst_n = 1'b1;
        bus_read(REG_A, 1'b1, rd, er);
        check("R8 word cleared", rd, 32'h0);
        set_wfi(5'h1F);
        repeat (3) @(negedge clk);
        check("R8 no reset", {27'h0, lowmask()}, 32'h0);

        // R9: unprivileged write ignored
        bus_write(REG_A, 32'h10F, 1'b0);
        @(negedge clk);
        check("R9 no reset", {27'h0, lowmask()}, 32'h0);
        bus_read(REG_A, 1'b1, rd, er);
        check("R9 word unchanged", rd, 32'h0);

        // R10 / R11: read privilege and error pulse
        set_wfi(5'h00);
        bus_write(REG_A, 32'h8, 1'b1);
        bus_read(REG_A, 1'b0, rd, er);
        check("R10 data zero", rd, 32'h0);
        check("R10 error raised", {31'h0, er}, 32'h1);
        @(negedge clk);
        check("R10 error one cycle", {31'h0, bus_err}, 32'h0);
        bus_read(REG_A, 1'b1, rd, er);
        check("R11 priv read", rd, 32'h8);
        check("R11 no error", {31'h0, er}, 32'h0);
        drain();

        // R11: other address
        set_wfi(5'h1F);
        bus_write(12'h030, 32'h1, 1'b1);
        @(negedge clk);
        check("R11 other addr write", {27'h0, lowmask()}, 32'h0);
        bus_read(12'h030, 1'b1, rd, er);
        check("R11 other addr read", rd, 32'h0);
        check("R11 other addr no error", {31'h0, er}, 32'h0);
        bus_read(REG_A, 1'b1, rd, er);
        check("R11 word untouched", rd, 32'h0);

        finish_run();
    end

endmodule